// File: doc/BRIEF.md
# Sub-pixel edge position clock generator

This block produces the fast clocks that read out an image sensor: a reset-gate clock, four horizontal transfer clocks (two pairs of complements), two correlated-sampling strobes and a strobe that latches the converter's output word. It runs on a fast clock with 48 ticks per pixel. A phase counter from 0 to 47 is restarted by a pixel-start input, and every edge of every output is placed on one of those 48 steps.

Edge positions come in as 6-bit codes. The upper two bits pick one of four groups of 12 steps and the lower four bits give the step inside that group. A code whose lower four bits exceed 11 does not name a step: it makes no edge and raises a sticky error flag. Each driven output has a 3-bit drive setting, and a zero setting drops that output's enable. A blanking input from a neighbouring block can hold the horizontal clocks at a supplied level.

Top module: `edge_clock_gen`

## Requirements
- R1: `pix_start` high at a rising clock edge makes the internal phase 0 after that edge. Otherwise the phase advances by one per clock, and 47 is followed by 0.
- R2: An edge code is decoded as position = code[5:4] × 12 + code[3:0]. For example, 0x2B is position 35.
- R3: A code with code[3:0] in 12..15 produces no edge. Any such code on any code input at a clock edge sets `code_err` after that edge. `code_err` then stays high until reset.
- R4: The reset-gate level goes high one clock after a tick whose phase equals the rising position. It goes low one clock after a tick whose phase equals the falling position. When both positions are equal, rising wins. `rg` is that level XOR `rg_inv`.
- R5: `h1` and `h3` both equal the shared horizontal level XOR `h_inv`. The shared level follows the R4 rules, using `h_rise_code` and `h_fall_code`. `h2` is always the complement of `h1`, and `h4` is always the complement of `h3`.
- R6: While `mask_act` is high, `h1` and `h3` equal `mask_lvl` in the same cycle, and `h2` and `h4` remain their complements.
- R7: `shp` and `shd` are high for exactly the one clock that follows a tick whose phase equals their decoded position.
- R8: `dout_lat` follows the R7 rule, using `dout_code`. Any of the 48 positions can be selected.
- R9: Each output enable is high exactly when its 3-bit drive setting is nonzero. Settings 1 to 7 all enable the output.
- R10: While reset is held, the phase, all levels and all strobes are 0 and `code_err` is 0.
- R11: The package's power-up codes are 0x00/0x10 for the reset gate, 0x00/0x20 for the horizontal clocks, 0x24 for `shp` and 0x00 for `shd`. These decode to positions 0, 12, 0, 24, 28 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 ticks per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_start | input | 1 | Realigns the phase to 0 |
| rg_rise_code | input | 6 | Reset-gate rising position code |
| rg_fall_code | input | 6 | Reset-gate falling position code |
| rg_inv | input | 1 | Inverts the reset-gate output |
| h_rise_code | input | 6 | Shared horizontal rising position code |
| h_fall_code | input | 6 | Shared horizontal falling position code |
| h_inv | input | 1 | Inverts `h1` and `h3` |
| shp_code | input | 6 | Reference-sample strobe position code |
| shd_code | input | 6 | Data-sample strobe position code |
| dout_code | input | 6 | Output-latch strobe position code |
| rg_drv | input | 3 | Reset-gate drive setting |
| h1_drv | input | 3 | `h1` drive setting |
| h2_drv | input | 3 | `h2` drive setting |
| h3_drv | input | 3 | `h3` drive setting |
| h4_drv | input | 3 | `h4` drive setting |
| mask_act | input | 1 | Blanking mask active |
| mask_lvl | input | 1 | Level forced on `h1`/`h3` while masked |
| rg | output | 1 | Reset-gate clock |
| rg_oe | output | 1 | Reset-gate enable |
| h1 | output | 1 | Horizontal clock 1 |
| h1_oe | output | 1 | `h1` enable |
| h2 | output | 1 | Horizontal clock 2 (complement of `h1`) |
| h2_oe | output | 1 | `h2` enable |
| h3 | output | 1 | Horizontal clock 3 |
| h3_oe | output | 1 | `h3` enable |
| h4 | output | 1 | Horizontal clock 4 (complement of `h3`) |
| h4_oe | output | 1 | `h4` enable |
| shp | output | 1 | Reference-sample strobe |
| shd | output | 1 | Data-sample strobe |
| dout_lat | output | 1 | Output-latch strobe |
| code_err | output | 1 | Sticky invalid-code flag |

## Verification
The power-up codes are run with a regular pixel-start cadence. This separates the R11 decode and the one-tick latency from phase-counter wrap faults. Directed codes in the upper quadrants and equal rise/fall positions check the quadrant arithmetic and the rise-wins rule. Early pixel-start pulses tell realignment apart from free-running wrap. A long stretch of random codes, inversions, masks and drive settings, with occasional invalid codes, is compared every clock against a behavioural model. That run tells mask priority, complement pairing and error stickiness apart from plain level tracking.

// File: rtl/ecg_pkg.sv
// Shared constants, types and power-up edge codes for the edge clock generator.
package ecg_pkg;
    localparam int STEPS  = 48;
    localparam int CODE_W = 6;
    localparam int DRV_W  = 3;

    // Power-up codes for the neighbouring register block (R11).
    localparam logic [CODE_W-1:0] PWRUP_RG_RISE = 6'h00;
    localparam logic [CODE_W-1:0] PWRUP_RG_FALL = 6'h10;
    localparam logic [CODE_W-1:0] PWRUP_H_RISE  = 6'h00;
    localparam logic [CODE_W-1:0] PWRUP_H_FALL  = 6'h20;
    localparam logic [CODE_W-1:0] PWRUP_SHP     = 6'h24;
    localparam logic [CODE_W-1:0] PWRUP_SHD     = 6'h00;

    // Index of each code input in the decode bank.
    localparam int IDX_RG_RISE = 0;
    localparam int IDX_RG_FALL = 1;
    localparam int IDX_H_RISE  = 2;
    localparam int IDX_H_FALL  = 3;
    localparam int IDX_SHP     = 4;
    localparam int IDX_SHD     = 5;
    localparam int IDX_DOUT    = 6;
    localparam int N_CODES     = 7;

    // Index of each driven output in the enable bank.
    localparam int N_DRIVEN = 5;

    // Decoded edge: a position and whether the code named a real step.
    typedef struct packed {
        logic              ok;
        logic [CODE_W-1:0] pos;
    } edge_pos_t;
endpackage

// File: rtl/ecg_phase_ctr.sv
// Phase counter: counts 0..STEPS-1 once per pixel.
// Assumes pix_start is synchronous to clk; it wins over the wrap.
module ecg_phase_ctr #(
    parameter int STEPS = 48,
    localparam int PH_W = $clog2(STEPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_start,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(STEPS - 1);

    // Realign on pixel start, otherwise advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (pix_start)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/ecg_edge_decode.sv
// Quadrant-code decoder: top two bits choose a group of STEPS/4 steps,
// the remaining bits give the offset inside it. Offsets past the group
// size are flagged as not ok. Purely combinational.
module ecg_edge_decode
    import ecg_pkg::*;
#(
    parameter int STEPS = 48,
    localparam int QUAD_STEPS = STEPS / 4,
    localparam int OFF_W      = CODE_W - 2
) (
    input  logic [CODE_W-1:0] code,
    output edge_pos_t         dec
);
    logic [1:0]       quad;
    logic [OFF_W-1:0] offs;

    // Split the code and form quad*QUAD_STEPS + offset.
    always_comb begin
        quad    = code[CODE_W-1 -: 2];
        offs    = code[OFF_W-1:0];
        dec.ok  = (int'(offs) < QUAD_STEPS);
        dec.pos = CODE_W'(int'(quad) * QUAD_STEPS + int'(offs));
    end
endmodule

// File: rtl/ecg_level_gen.sv
// Two-edge level generator: sets at the rising position, clears at the
// falling position, one clock after the matching phase. Rise wins a tie.
// Assumes ok flags come from the decoder; invalid edges are ignored.
module ecg_level_gen
    import ecg_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  edge_pos_t       rise,
    input  edge_pos_t       fall,
    output logic            level
);
    logic hit_rise, hit_fall;

    // Compare the current phase with each decoded edge.
    always_comb begin
        hit_rise = rise.ok && (CODE_W'(phase) == rise.pos);
        hit_fall = fall.ok && (CODE_W'(phase) == fall.pos);
    end

    // Hold the level between edges; rise has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= 1'b0;
        else if (hit_rise)
            level <= 1'b1;
        else if (hit_fall)
            level <= 1'b0;
    end
endmodule

// File: rtl/ecg_strobe_gen.sv
// One-tick strobe: high for the clock after the phase equals the position.
module ecg_strobe_gen
    import ecg_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  edge_pos_t       at,
    output logic            strobe
);
    // Register the position match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe <= 1'b0;
        else
            strobe <= at.ok && (CODE_W'(phase) == at.pos);
    end
endmodule

// File: rtl/edge_clock_gen.sv
// Sub-pixel edge clock generator top. Decodes seven edge codes, drives the
// reset-gate level, the shared horizontal level and three strobes from one
// phase counter, applies polarity and blanking, and derives enables from
// drive settings. Assumes all code inputs are static or change synchronously.
module edge_clock_gen
    import ecg_pkg::*;
#(
    parameter int STEPS = ecg_pkg::STEPS,
    localparam int PH_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_start,
    input  logic [CODE_W-1:0] rg_rise_code,
    input  logic [CODE_W-1:0] rg_fall_code,
    input  logic              rg_inv,
    input  logic [CODE_W-1:0] h_rise_code,
    input  logic [CODE_W-1:0] h_fall_code,
    input  logic              h_inv,
    input  logic [CODE_W-1:0] shp_code,
    input  logic [CODE_W-1:0] shd_code,
    input  logic [CODE_W-1:0] dout_code,
    input  logic [DRV_W-1:0]  rg_drv,
    input  logic [DRV_W-1:0]  h1_drv,
    input  logic [DRV_W-1:0]  h2_drv,
    input  logic [DRV_W-1:0]  h3_drv,
    input  logic [DRV_W-1:0]  h4_drv,
    input  logic              mask_act,
    input  logic              mask_lvl,
    output logic              rg,
    output logic              rg_oe,
    output logic              h1,
    output logic              h1_oe,
    output logic              h2,
    output logic              h2_oe,
    output logic              h3,
    output logic              h3_oe,
    output logic              h4,
    output logic              h4_oe,
    output logic              shp,
    output logic              shd,
    output logic              dout_lat,
    output logic              code_err
);
    logic [PH_W-1:0]          phase_q;
    logic [CODE_W-1:0]        codes [N_CODES];
    edge_pos_t                dec   [N_CODES];
    logic [N_CODES-1:0]       bad_vec;
    logic [DRV_W-1:0]         drv   [N_DRIVEN];
    logic [N_DRIVEN-1:0]      oe_vec;
    logic                     rg_lvl, h_lvl, h_pair;
    logic                     err_q;
    edge_pos_t                shp_dec;

    // Gather code inputs into the decode bank.
    always_comb begin
        codes[IDX_RG_RISE] = rg_rise_code;
        codes[IDX_RG_FALL] = rg_fall_code;
        codes[IDX_H_RISE]  = h_rise_code;
        codes[IDX_H_FALL]  = h_fall_code;
        codes[IDX_SHP]     = shp_code;
        codes[IDX_SHD]     = shd_code;
        codes[IDX_DOUT]    = dout_code;
    end

    ecg_phase_ctr #(.STEPS(STEPS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_start(pix_start),
        .phase    (phase_q)
    );

    // One decoder per code input.
    for (genvar i = 0; i < N_CODES; i++) begin : g_dec
        ecg_edge_decode #(.STEPS(STEPS)) u_dec (
            .code(codes[i]),
            .dec (dec[i])
        );
        assign bad_vec[i] = ~dec[i].ok;
    end

    assign shp_dec = dec[IDX_SHP];

    ecg_level_gen #(.PH_W(PH_W)) u_rg_lvl (
        .clk  (clk),
        .rst_n(rst_n),
        .phase(phase_q),
        .rise (dec[IDX_RG_RISE]),
        .fall (dec[IDX_RG_FALL]),
        .level(rg_lvl)
    );

    ecg_level_gen #(.PH_W(PH_W)) u_h_lvl (
        .clk  (clk),
        .rst_n(rst_n),
        .phase(phase_q),
        .rise (dec[IDX_H_RISE]),
        .fall (dec[IDX_H_FALL]),
        .level(h_lvl)
    );

    ecg_strobe_gen #(.PH_W(PH_W)) u_shp (
        .clk(clk), .rst_n(rst_n), .phase(phase_q), .at(dec[IDX_SHP]), .strobe(shp)
    );
    ecg_strobe_gen #(.PH_W(PH_W)) u_shd (
        .clk(clk), .rst_n(rst_n), .phase(phase_q), .at(dec[IDX_SHD]), .strobe(shd)
    );
    ecg_strobe_gen #(.PH_W(PH_W)) u_dout (
        .clk(clk), .rst_n(rst_n), .phase(phase_q), .at(dec[IDX_DOUT]), .strobe(dout_lat)
    );

    // Sticky invalid-code flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= err_q | (|bad_vec);
    end
    assign code_err = err_q;

    // Polarity and blanking for the clock outputs.
    always_comb begin
        rg     = rg_lvl ^ rg_inv;
        h_pair = mask_act ? mask_lvl : (h_lvl ^ h_inv);
        h1     = h_pair;
        h3     = h_pair;
        h2     = ~h1;
        h4     = ~h3;
    end

    // Drive settings to enables: zero means three-stated.
    always_comb begin
        drv[0] = rg_drv;
        drv[1] = h1_drv;
        drv[2] = h2_drv;
        drv[3] = h3_drv;
        drv[4] = h4_drv;
    end
    for (genvar d = 0; d < N_DRIVEN; d++) begin : g_oe
        assign oe_vec[d] = |drv[d];
    end
    assign {h4_oe, h3_oe, h2_oe, h1_oe, rg_oe} = oe_vec;
endmodule

// File: rtl/ecg_chk.sv
// Assertion checker for edge_clock_gen, attached with bind below.
module ecg_chk
    import ecg_pkg::*;
#(
    parameter int STEPS = 48,
    localparam int PH_W = $clog2(STEPS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pix_start,
    input logic [PH_W-1:0] phase,
    input edge_pos_t       shp_at,
    input logic            shp,
    input logic            code_err,
    input logic            mask_act,
    input logic            mask_lvl,
    input logic            h1,
    input logic            h2,
    input logic            h3,
    input logic            h4,
    input logic [DRV_W-1:0] rg_drv,
    input logic            rg_oe
);
    // R1
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_start |=> (phase == '0));
    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_start && phase == PH_W'(STEPS - 1)) |=> (phase == '0));
    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);
    // R7
    shp_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shp) |-> $past(shp_at.ok && CODE_W'(phase) == shp_at.pos));
    // R6
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_act |-> (h1 == mask_lvl && h3 == mask_lvl && h2 != h1 && h4 != h3));
    // R9
    oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_drv == '0) |-> !rg_oe);
endmodule

bind edge_clock_gen ecg_chk #(.STEPS(STEPS)) u_ecg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_start(pix_start),
    .phase    (phase_q),
    .shp_at   (shp_dec),
    .shp      (shp),
    .code_err (code_err),
    .mask_act (mask_act),
    .mask_lvl (mask_lvl),
    .h1       (h1),
    .h2       (h2),
    .h3       (h3),
    .h4       (h4),
    .rg_drv   (rg_drv),
    .rg_oe    (rg_oe)
);

// File: tb/tb_edge_clock_gen.sv
`timescale 1ns/1ps
module tb_edge_clock_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_start = 1'b0;
    logic [5:0] rg_rise_code, rg_fall_code, h_rise_code, h_fall_code;
    logic [5:0] shp_code, shd_code, dout_code;
    logic rg_inv = 1'b0, h_inv = 1'b0, mask_act = 1'b0, mask_lvl = 1'b0;
    logic [2:0] rg_drv, h1_drv, h2_drv, h3_drv, h4_drv;
    logic rg, rg_oe, h1, h1_oe, h2, h2_oe, h3, h3_oe, h4, h4_oe;
    logic shp, shd, dout_lat, code_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Model state
    int m_phase = 0;
    bit m_rg = 0, m_h = 0, m_shp = 0, m_shd = 0, m_dl = 0, m_err = 0;

    always #2.5 clk = ~clk;

    edge_clock_gen dut (
        .clk(clk), .rst_n(rst_n), .pix_start(pix_start),
        .rg_rise_code(rg_rise_code), .rg_fall_code(rg_fall_code), .rg_inv(rg_inv),
        .h_rise_code(h_rise_code), .h_fall_code(h_fall_code), .h_inv(h_inv),
        .shp_code(shp_code), .shd_code(shd_code), .dout_code(dout_code),
        .rg_drv(rg_drv), .h1_drv(h1_drv), .h2_drv(h2_drv), .h3_drv(h3_drv), .h4_drv(h4_drv),
        .mask_act(mask_act), .mask_lvl(mask_lvl),
        .rg(rg), .rg_oe(rg_oe), .h1(h1), .h1_oe(h1_oe), .h2(h2), .h2_oe(h2_oe),
        .h3(h3), .h3_oe(h3_oe), .h4(h4), .h4_oe(h4_oe),
        .shp(shp), .shd(shd), .dout_lat(dout_lat), .code_err(code_err)
    );

    // Position of a code, or -1 when the offset names no step (R2, R3).
    function automatic int pos_of(logic [5:0] c);
        if (c[3:0] > 4'd11) return -1;
        return int'(c[5:4]) * 12 + int'(c[3:0]);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance the model by one clock from the current inputs.
    task automatic model_edge();
        int rr, rf, hr, hf;
        if (!rst_n) begin
            m_phase = 0; m_rg = 0; m_h = 0; m_shp = 0; m_shd = 0; m_dl = 0; m_err = 0;
            return;
        end
        rr = pos_of(rg_rise_code); rf = pos_of(rg_fall_code);
        hr = pos_of(h_rise_code);  hf = pos_of(h_fall_code);
        if (rr >= 0 && m_phase == rr) m_rg = 1;
        else if (rf >= 0 && m_phase == rf) m_rg = 0;
        if (hr >= 0 && m_phase == hr) m_h = 1;
        else if (hf >= 0 && m_phase == hf) m_h = 0;
        m_shp = (pos_of(shp_code) == m_phase);
        m_shd = (pos_of(shd_code) == m_phase);
        m_dl  = (pos_of(dout_code) == m_phase);
        if (rr < 0 || rf < 0 || hr < 0 || hf < 0 || pos_of(shp_code) < 0 ||
            pos_of(shd_code) < 0 || pos_of(dout_code) < 0)
            m_err = 1;
        m_phase = pix_start ? 0 : (m_phase + 1) % 48;
    endtask

    // Compare every output against the model.
    task automatic compare();
        bit hp;
        hp = mask_act ? mask_lvl : (m_h ^ h_inv);
        check("R4 rg", rg, m_rg ^ rg_inv);
        check(mask_act ? "R6 h1" : "R5 h1", h1, hp);
        check(mask_act ? "R6 h3" : "R5 h3", h3, hp);
        check("R5 h2", h2, ~hp);
        check("R5 h4", h4, ~hp);
        check("R7 shp", shp, m_shp);
        check("R7 shd", shd, m_shd);
        check("R8 dout_lat", dout_lat, m_dl);
        check("R3 code_err", code_err, m_err);
        check("R9 rg_oe", rg_oe, rg_drv != 0);
        check("R9 h1_oe", h1_oe, h1_drv != 0);
        check("R9 h2_oe", h2_oe, h2_drv != 0);
        check("R9 h3_oe", h3_oe, h3_drv != 0);
        check("R9 h4_oe", h4_oe, h4_drv != 0);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    // Pulse pix_start, then count clocks until the chosen strobe rises.
    task automatic clocks_to_strobe(bit use_shd, output int n);
        pix_start = 1; step(); pix_start = 0;
        n = 0;
        do begin
            step(); n++;
        end while (!(use_shd ? shd : shp) && n < 100);
    endtask

    task automatic load_pwrup();
        rg_rise_code = 6'h00; rg_fall_code = 6'h10;
        h_rise_code  = 6'h00; h_fall_code  = 6'h20;
        shp_code = 6'h24; shd_code = 6'h00; dout_code = 6'h1A;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        load_pwrup();
        rg_drv = 3'd3; h1_drv = 3'd3; h2_drv = 3'd3; h3_drv = 3'd3; h4_drv = 3'd3;
        rg_inv = 1;
        for (int i = 0; i < 4; i++) step();
        // R10: reset state
        check("R10 rg in reset", rg, 1'b1);
        check("R10 shp in reset", shp, 1'b0);
        check("R10 code_err in reset", code_err, 1'b0);
        rg_inv = 0;
        rst_n = 1;

        // R11 / R1: power-up codes with regular pixel starts
        clocks_to_strobe(0, n);
        check_int("R11 shp at pwrup position 28", n, 29);
        for (int p = 0; p < 3; p++) begin
            pix_start = 1; step(); pix_start = 0;
            for (int k = 0; k < 47; k++) step();
        end

        // R2: upper quadrant decode
        shd_code = 6'h2B;
        clocks_to_strobe(1, n);
        check_int("R2 shd code 0x2B position 35", n, 36);
        shd_code = 6'h3B;
        clocks_to_strobe(1, n);
        check_int("R2 shd code 0x3B position 47", n, 48);

        // R4: equal rise and fall, rise wins; inversion
        rg_rise_code = 6'h05; rg_fall_code = 6'h05; rg_inv = 1;
        for (int k = 0; k < 60; k++) step();
        check("R4 tie keeps level high", rg, 1'b0);
        rg_inv = 0; rg_fall_code = 6'h31;

        // R1: early realignment
        for (int k = 0; k < 20; k++) begin
            pix_start = (k % 7 == 0); step();
        end
        pix_start = 0;

        // R6: masking
        h_inv = 1; mask_act = 1; mask_lvl = 1;
        for (int k = 0; k < 50; k++) begin
            mask_lvl = (k % 3 == 0); step();
        end
        mask_act = 0;

        // R9: drive settings, every value
        for (int v = 0; v < 8; v++) begin
            rg_drv = 3'(v); h1_drv = 3'(v); h2_drv = 3'(7 - v);
            h3_drv = 3'(v); h4_drv = 3'(v ^ 1); step();
        end

        // R3: invalid code makes no edge and sets sticky flag
        shp_code = 6'h0C;
        for (int k = 0; k < 50; k++) step();
        check("R3 code_err set", code_err, 1'b1);
        shp_code = 6'h24;
        for (int k = 0; k < 10; k++) step();
        check("R3 code_err stays", code_err, 1'b1);
        rst_n = 0; step(); rst_n = 1;
        check("R10 reset clears code_err", code_err, 1'b0);

        // Random run
        for (int k = 0; k < 6000; k++) begin
            if (k % 97 == 0) begin
                rg_rise_code = 6'($urandom_range(0, 63)) & 6'h3F;
                if (rg_rise_code[3:0] > 11 && ($urandom % 8 != 0)) rg_rise_code[3:0] = 4'd3;
                rg_fall_code = {2'($urandom), 4'($urandom_range(0, 11))};
                h_rise_code  = {2'($urandom), 4'($urandom_range(0, 11))};
                h_fall_code  = {2'($urandom), 4'($urandom_range(0, 11))};
                shp_code     = {2'($urandom), 4'($urandom_range(0, 11))};
                shd_code     = {2'($urandom), 4'($urandom_range(0, 11))};
                dout_code    = {2'($urandom), 4'($urandom_range(0, 11))};
                rg_inv = 1'($urandom); h_inv = 1'($urandom);
                rg_drv = 3'($urandom); h1_drv = 3'($urandom); h2_drv = 3'($urandom);
                h3_drv = 3'($urandom); h4_drv = 3'($urandom);
            end
            if (k == 3000) begin rst_n = 0; step(); rst_n = 1; end
            mask_act = ($urandom % 10 == 0);
            mask_lvl = 1'($urandom);
            pix_start = ($urandom % 40 == 0);
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule